// File: doc/BRIEF.md
# Masked Selective Register Load Unit

This unit computes the value written back to a general register by a selective load. It takes an effective word fetched from memory, the 4-bit destination register field, the current contents of that destination register, and the contents of its partner register. The low bit of the register field picks the operation.

When the field is even, the partner register (the odd register of the even/odd pair) supplies a bit mask. Each mask bit set to 1 takes the effective-word bit, and each mask bit at 0 keeps the old destination bit. When the field is odd, the new value is the bitwise AND of the effective word and the old destination, and the partner value plays no part.

The unit also reports the index of the partner register so that the register file can read the mask. The result, a one-cycle write enable and the two low condition-code bits are registered on a valid strobe. The two high condition-code bits belong to the surrounding pipeline and are not touched here.

Top module: `sel_load_unit`

## Requirements
- R1: For an even register field, each bit of the result equals the effective-word bit where the partner bit is 1 and the old destination bit where the partner bit is 0.
- R2: For an odd register field, the result equals the effective word ANDed bitwise with the old destination.
- R3: For an odd register field, the partner value has no effect on the result or on the condition code.
- R4: The condition-code output `cc_o` (bit 1 is CC3, bit 0 is CC4) is 2'b00 when the result is zero.
- R5: `cc_o` is 2'b10 when result bit 31 (the word's most significant bit, the sign bit) is 1.
- R6: `cc_o` is 2'b01 when result bit 31 is 0 and at least one of bits 30..0 is 1.
- R7: `wr_en_o` is 1 for exactly the cycle after each clock edge at which `valid_i` was 1, and 0 after every edge at which `valid_i` was 0.
- R8: After an edge at which `valid_i` is 0, `result_o` and `cc_o` keep their previous values.
- R9: While synchronous active-high `rst` is sampled as 1, `result_o`, `cc_o` and `wr_en_o` are cleared to zero at the next edge.
- R10: `mask_sel_o` is combinationally equal to the register field with its lowest bit forced to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands are present this cycle |
| rfield_i | input | 4 | Destination register field |
| eword_i | input | 32 | Effective word from memory |
| dest_i | input | 32 | Current contents of the destination register |
| pair_i | input | 32 | Contents of the partner (mask) register |
| mask_sel_o | output | 4 | Index of the partner register to read |
| result_o | output | 32 | New destination value |
| wr_en_o | output | 1 | Write strobe for the destination register |
| cc_o | output | 2 | New CC3 (bit 1) and CC4 (bit 0) |

## Verification
The partner index is combinational, so the bench checks it in the same cycle that the field is driven. The result, the condition code and the write enable come one clock edge after the valid strobe. The bench drives each operand set on a falling edge, lets exactly one rising edge capture it, and reads the outputs at the next falling edge, where `wr_en_o` must still be 1. Hold behaviour and reset are read one further falling edge later, after an edge that had `valid_i` low or `rst` high.

// File: rtl/sel_load_pkg.sv
package sel_load_pkg;
  localparam int DATA_W = 32;
  localparam int RIDX_W = 4;

  typedef enum logic [1:0] {
    CC_ZERO = 2'b00,
    CC_POS  = 2'b01,
    CC_NEG  = 2'b10
  } cc_code_t;
endpackage

// File: rtl/sel_merge.sv
module sel_merge #(
  parameter int W = 32
) (
  input  logic         odd_sel,
  input  logic [W-1:0] eword,
  input  logic [W-1:0] dest,
  input  logic [W-1:0] pair,
  output logic [W-1:0] merged
);
  // per-bit select: odd forces AND, even picks by mask bit
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (odd_sel)
        merged[b] = eword[b] & dest[b];
      else
        merged[b] = pair[b] ? eword[b] : dest[b];
    end
  end
endmodule

// File: rtl/sel_cc_class.sv
module sel_cc_class
  import sel_load_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output cc_code_t     code
);
  localparam int MSB = W - 1;

  always_comb begin
    if (value[MSB])
      code = CC_NEG;
    else if (|value[MSB-1:0])
      code = CC_POS;
    else
      code = CC_ZERO;
  end
endmodule

// File: rtl/sel_load_unit.sv
module sel_load_unit
  import sel_load_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int RW = RIDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [RW-1:0] rfield_i,
  input  logic [W-1:0]  eword_i,
  input  logic [W-1:0]  dest_i,
  input  logic [W-1:0]  pair_i,
  output logic [RW-1:0] mask_sel_o,
  output logic [W-1:0]  result_o,
  output logic          wr_en_o,
  output logic [1:0]    cc_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] merged;
  cc_code_t     next_cc;

  assign mask_sel_o = {rfield_i[RW-1:1], 1'b1};

  sel_merge #(.W(W)) u_merge (
    .odd_sel (rfield_i[0]),
    .eword   (eword_i),
    .dest    (dest_i),
    .pair    (pair_i),
    .merged  (merged)
  );

  sel_cc_class #(.W(W)) u_cc (
    .value (merged),
    .code  (next_cc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      cc_o     <= 2'b00;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= valid_i;
      if (valid_i) begin
        result_o <= merged;
        cc_o     <= next_cc;
      end
    end
  end

  // R1
  even_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !rfield_i[0]) |=> result_o ==
      (($past(eword_i) & $past(pair_i)) | ($past(dest_i) & ~$past(pair_i))));

  // R2
  odd_and_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && rfield_i[0]) |=> result_o == ($past(eword_i) & $past(dest_i)));

  // R4
  zero_cc_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && result_o == '0) |-> cc_o == 2'b00);

  // R5
  sign_cc_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && result_o[MSB]) |-> cc_o == 2'b10);

  // R6
  pos_cc_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !result_o[MSB] && result_o != '0) |-> cc_o == 2'b01);

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> wr_en_o);

  // R7
  wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !wr_en_o);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(result_o) && $stable(cc_o)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result_o == '0 && cc_o == 2'b00 && !wr_en_o));

  // R10
  always_comb begin
    mask_sel_odd_chk: assert (mask_sel_o[0] == 1'b1 || $isunknown(rfield_i));
  end
endmodule

// File: tb/sel_load_unit_test.sv
module sel_load_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [3:0]  rfield_i;
  logic [31:0] eword_i, dest_i, pair_i;
  logic [3:0]  mask_sel_o;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [1:0]  cc_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sel_load_unit uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .rfield_i(rfield_i),
    .eword_i(eword_i), .dest_i(dest_i), .pair_i(pair_i),
    .mask_sel_o(mask_sel_o), .result_o(result_o),
    .wr_en_o(wr_en_o), .cc_o(cc_o)
  );

  localparam int NV = 9;
  localparam logic [3:0]  V_R [NV] = '{4'd2, 4'd5, 4'd0, 4'd14, 4'd7, 4'd9, 4'd12, 4'd15, 4'd4};
  localparam logic [31:0] V_EW[NV] = '{32'h01234567, 32'h89ABCDEF, 32'hFFFFFFFF, 32'h80000000,
                                       32'h0F0F0F0F, 32'h7FFFFFFF, 32'h00000001, 32'hFFFFFFFF,
                                       32'h00000000};
  localparam logic [31:0] V_D [NV] = '{32'hAABBCCDD, 32'hF0F0F0F0, 32'h00000000, 32'h12345678,
                                       32'hF0F0F0F0, 32'hFFFFFFFF, 32'h00000000, 32'h80000001,
                                       32'hDEADBEEF};
  localparam logic [31:0] V_P [NV] = '{32'hFF00FF00, 32'h12345678, 32'h00000000, 32'hFFFFFFFF,
                                       32'hFFFFFFFF, 32'h00000000, 32'h0000000F, 32'h00000000,
                                       32'h0000FFFF};
  localparam logic [31:0] V_RES[NV] = '{32'h01BB45DD, 32'h80A0C0E0, 32'h00000000, 32'h80000000,
                                        32'h00000000, 32'h7FFFFFFF, 32'h00000001, 32'h80000001,
                                        32'hDEAD0000};
  localparam logic [1:0]  V_CC[NV] = '{2'b01, 2'b10, 2'b00, 2'b10, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, one rising edge captures, read at next falling edge
  task automatic apply(input logic [3:0] r, input logic [31:0] ew,
                       input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    rfield_i = r; eword_i = ew; dest_i = d; pair_i = p; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r_a;
    logic [1:0]  c_a;
    rst = 1'b1; valid_i = 1'b0; rfield_i = '0;
    eword_i = '0; dest_i = '0; pair_i = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", result_o, 32'h0);
    check("R9 cc", {30'b0, cc_o}, 32'h0);
    check("R9 wr_en", {31'b0, wr_en_o}, 32'h0);
    rst = 1'b0;

    // vector table: R1/R2 data, R4/R5/R6 codes, R7 strobe
    for (int i = 0; i < NV; i++) begin
      apply(V_R[i], V_EW[i], V_D[i], V_P[i]);
      check(V_R[i][0] ? "R2 result" : "R1 result", result_o, V_RES[i]);
      check(V_CC[i] == 2'b00 ? "R4 cc" : (V_CC[i] == 2'b10 ? "R5 cc" : "R6 cc"),
            {30'b0, cc_o}, {30'b0, V_CC[i]});
      check("R7 wr_en high", {31'b0, wr_en_o}, 32'h1);
    end

    // R7 / R8: idle edge clears strobe, holds data
    r_a = result_o; c_a = cc_o;
    eword_i = 32'h55555555; dest_i = 32'hAAAAAAAA; rfield_i = 4'd3;
    @(negedge clk);
    check("R7 wr_en low", {31'b0, wr_en_o}, 32'h0);
    check("R8 result hold", result_o, r_a);
    check("R8 cc hold", {30'b0, cc_o}, {30'b0, c_a});

    // R3: odd field, partner changes, outcome unchanged
    apply(4'd11, 32'hC3C3C3C3, 32'h0FF00FF0, 32'h00000000);
    check("R3 result p0", result_o, 32'h03C003C0);
    check("R3 cc p0", {30'b0, cc_o}, 32'h1);
    apply(4'd11, 32'hC3C3C3C3, 32'h0FF00FF0, 32'hFFFFFFFF);
    check("R3 result p1", result_o, 32'h03C003C0);
    check("R3 cc p1", {30'b0, cc_o}, 32'h1);

    // R10: partner index for every field value
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      rfield_i = 4'(r);
      #1;
      check("R10 mask_sel", {28'b0, mask_sel_o}, {28'b0, 4'(r) | 4'd1});
    end

    // R9: reset mid-run clears outputs even with valid high
    apply(4'd6, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
    check("R5 pre-reset cc", {30'b0, cc_o}, 32'h2);
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b1;
    @(negedge clk);
    check("R9 result mid", result_o, 32'h0);
    check("R9 cc mid", {30'b0, cc_o}, 32'h0);
    check("R9 wr_en mid", {31'b0, wr_en_o}, 32'h0);
    rst = 1'b0; valid_i = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule